// File: doc/BRIEF.md
# Conditional branch decision unit

This purely combinational unit decides whether a branch is taken. It also works out the program counter that execution continues from. A branch-kind code selects one of four groups of branch:

- tests on the N, Z, V and C condition flags;
- loop-counter forms that decrement, increment or simply test a 16-bit counter;
- bit-test forms that AND a memory operand with a mask;
- the unconditional always and never forms.

The unit is placed after instruction decode. Decode supplies the kind code, the flags, the instruction's address and byte length, a signed displacement, the counter value and the operand and mask. The unit returns three results: the taken decision, the resulting program counter and the counter value to be written back. Writeback itself is done elsewhere.

The groups measure the target from different bases. Flag and bit-test branches measure it from the next instruction, which is the address plus the length. The counter forms always measure it from the address plus 3. The displacement is sign-extended before the add, and all address and counter arithmetic wraps modulo 2^16.

Top module: `branch_decider`

## Requirements
- R1: Kind code 0 (always) is taken for every flag value. Kind code 1 (never) is never taken and yields the fall-through address.
- R2: The unsigned flag forms are decided as follows. Code 2 (higher) is taken when C|Z is 0 and code 3 (lower-or-same) when C|Z is 1. Code 4 (carry clear / higher-or-same) is taken when C=0 and code 5 (carry set / lower) when C=1. The flags input carries N, Z, V and C in bits 3, 2, 1 and 0.
- R3: The simple flag forms are decided as follows. Code 6 is taken when Z=0 and code 7 when Z=1. Code 8 is taken when V=0 and code 9 when V=1. Code 10 is taken when N=0 and code 11 when N=1.
- R4: The signed flag forms are decided as follows. Code 12 (greater-or-equal) is taken when N^V is 0 and code 13 (less) when N^V is 1. Code 14 (greater) is taken when Z|(N^V) is 0 and code 15 (less-or-equal) when Z|(N^V) is 1.
- R5: For every code other than 16 to 21, the result address depends on the decision. When taken it is address + length + sign-extended displacement. When not taken it is address + length. Both wrap modulo 2^16.
- R6: Codes 16 and 17 output counter-1 modulo 2^16. Code 16 is taken when that new value is zero and code 17 when it is nonzero.
- R7: Codes 18 and 19 output counter+1 modulo 2^16. Code 18 is taken when that new value is zero and code 19 when it is nonzero.
- R8: Codes 20 and 21 output the counter unchanged. Code 20 is taken when the counter is zero and code 21 when it is nonzero.
- R9: For codes 16 to 21 the result address ignores the length input. When taken it is address + 3 + sign-extended displacement. When not taken it is address + 3. Both wrap modulo 2^16.
- R10: Code 22 is taken when (operand & mask) equals mask, and code 23 when (operand & mask) is zero. With a zero mask, both codes are taken.
- R11: Codes 24 to 31 are never taken. Every code outside 16 to 19 leaves the counter output equal to the counter input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| br_kind | input | 5 | Branch kind code |
| flags_nzvc | input | 4 | Condition flags N,Z,V,C in bits 3..0 |
| inst_pc | input | 16 | Address of the branch instruction |
| inst_len | input | 3 | Instruction length in bytes |
| disp | input | 9 | Signed displacement |
| cnt_in | input | 16 | Loop counter value |
| opnd | input | 8 | Memory operand for bit tests |
| mask | input | 8 | Bit-test mask |
| taken | output | 1 | Branch taken |
| next_pc | output | 16 | Resulting program counter |
| cnt_out | output | 16 | Updated loop counter |

## Verification
The embedded checks assume that every input holds a known value; they skip any evaluation in which an input is still unknown. They also assume that the displacement is narrower than the address. The stimulus drives every input together, to fully defined values, right after each clock edge. It keeps the length at realistic values of 2 to 6 bytes and uses the default widths. Counter corners of 0, 1, 0x8000, 0xFFFE and 0xFFFF are applied to every counter form, and addresses close to 0xFFFF exercise the wrap of the target sum.

// File: rtl/branch_decider.sv
module branch_decider #(
  parameter int AW     = 16,
  parameter int CW     = 16,
  parameter int OW     = 8,
  parameter int DISP_W = 9,
  parameter int LEN_W  = 3
) (
  input  logic [4:0]        br_kind,
  input  logic [3:0]        flags_nzvc,
  input  logic [AW-1:0]     inst_pc,
  input  logic [LEN_W-1:0]  inst_len,
  input  logic [DISP_W-1:0] disp,
  input  logic [CW-1:0]     cnt_in,
  input  logic [OW-1:0]     opnd,
  input  logic [OW-1:0]     mask,
  output logic              taken,
  output logic [AW-1:0]     next_pc,
  output logic [CW-1:0]     cnt_out
);
  localparam logic [4:0] K_ALW = 5'd0,  K_NEV = 5'd1;
  localparam logic [4:0] K_HI  = 5'd2,  K_LS  = 5'd3,  K_CC  = 5'd4,  K_CS  = 5'd5;
  localparam logic [4:0] K_NE  = 5'd6,  K_EQ  = 5'd7,  K_VC  = 5'd8,  K_VS  = 5'd9;
  localparam logic [4:0] K_PL  = 5'd10, K_MI  = 5'd11;
  localparam logic [4:0] K_GE  = 5'd12, K_LT  = 5'd13, K_GT  = 5'd14, K_LE  = 5'd15;
  localparam logic [4:0] K_DBZ = 5'd16, K_DBN = 5'd17, K_IBZ = 5'd18, K_IBN = 5'd19;
  localparam logic [4:0] K_TBZ = 5'd20, K_TBN = 5'd21;
  localparam logic [4:0] K_BSET = 5'd22, K_BCLR = 5'd23;
  localparam int        EXT_W = AW - DISP_W;

  wire f_n = flags_nzvc[3];
  wire f_z = flags_nzvc[2];
  wire f_v = flags_nzvc[1];
  wire f_c = flags_nzvc[0];
  wire s_lt = f_n ^ f_v;
  wire s_le = f_z | s_lt;
  wire u_ls = f_c | f_z;

  wire is_dec = (br_kind == K_DBZ) || (br_kind == K_DBN);
  wire is_inc = (br_kind == K_IBZ) || (br_kind == K_IBN);
  wire is_cnt = (br_kind >= K_DBZ) && (br_kind <= K_TBN);

  wire [AW-1:0] disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  wire [OW-1:0] masked   = opnd & mask;

  logic [CW-1:0] cnt_new;
  logic [AW-1:0] base_pc;
  logic          cnt_zero;

  always_comb begin
    cnt_new  = is_dec ? cnt_in - CW'(1) : (is_inc ? cnt_in + CW'(1) : cnt_in);
    cnt_zero = (cnt_new == '0);
    base_pc  = is_cnt ? inst_pc + AW'(3) : inst_pc + AW'(inst_len);
    case (br_kind)
      K_ALW:  taken = 1'b1;
      K_NEV:  taken = 1'b0;
      K_HI:   taken = ~u_ls;
      K_LS:   taken = u_ls;
      K_CC:   taken = ~f_c;
      K_CS:   taken = f_c;
      K_NE:   taken = ~f_z;
      K_EQ:   taken = f_z;
      K_VC:   taken = ~f_v;
      K_VS:   taken = f_v;
      K_PL:   taken = ~f_n;
      K_MI:   taken = f_n;
      K_GE:   taken = ~s_lt;
      K_LT:   taken = s_lt;
      K_GT:   taken = ~s_le;
      K_LE:   taken = s_le;
      K_DBZ, K_IBZ, K_TBZ: taken = cnt_zero;
      K_DBN, K_IBN, K_TBN: taken = ~cnt_zero;
      K_BSET: taken = (masked == mask);
      K_BCLR: taken = (masked == '0);
      default: taken = 1'b0;
    endcase
    next_pc = taken ? base_pc + disp_ext : base_pc;
    cnt_out = cnt_new;

    if (!$isunknown({br_kind, flags_nzvc, inst_pc, inst_len, disp, cnt_in, opnd, mask})) begin
      p_always_r1: assert (br_kind != K_ALW || taken);
      p_never_r1:  assert (br_kind != K_NEV || (!taken && next_pc == inst_pc + AW'(inst_len)));
      p_dec_r6:    assert (!is_dec || cnt_out + CW'(1) == cnt_in);
      p_inc_r7:    assert (!is_inc || cnt_out - CW'(1) == cnt_in);
      p_hold_r11:  assert (is_dec || is_inc || cnt_out == cnt_in);
      p_fall_r9:   assert (!is_cnt || taken || next_pc - inst_pc == AW'(3));
      p_fall_r5:   assert (is_cnt || taken || next_pc - inst_pc == AW'(inst_len));
      p_bclr_r10:  assert (br_kind != K_BCLR || !taken || (opnd & mask) == '0);
      p_sgn_r4:    assert (!(br_kind == K_GT && taken) || (!f_z && f_n == f_v));
      p_undef_r11: assert (br_kind < 5'd24 || !taken);
    end
  end
endmodule

// File: tb/tb_branch_decider.sv
module tb_branch_decider;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  br_kind = '0;
  logic [3:0]  flags_nzvc = '0;
  logic [15:0] inst_pc = '0;
  logic [2:0]  inst_len = 3'd2;
  logic [8:0]  disp = '0;
  logic [15:0] cnt_in = '0;
  logic [7:0]  opnd = '0;
  logic [7:0]  mask = '0;
  logic        taken;
  logic [15:0] next_pc;
  logic [15:0] cnt_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  branch_decider dut (
    .br_kind(br_kind), .flags_nzvc(flags_nzvc), .inst_pc(inst_pc), .inst_len(inst_len),
    .disp(disp), .cnt_in(cnt_in), .opnd(opnd), .mask(mask),
    .taken(taken), .next_pc(next_pc), .cnt_out(cnt_out));

  function automatic string tag_of(int k);
    if (k <= 1) return "R1";
    if (k <= 5) return "R2";
    if (k <= 11) return "R3";
    if (k <= 15) return "R4";
    if (k <= 17) return "R6";
    if (k <= 19) return "R7";
    if (k <= 21) return "R8";
    if (k <= 23) return "R10";
    return "R11";
  endfunction

  task automatic run(int k, int fl, int pc, int len, int d, int cnt, int op, int mk);
    int n, z, v, c, dv, cv, tst, base, e_npc, e_cnt;
    bit e_t;
    @(posedge clk); #1;
    br_kind = 5'(k); flags_nzvc = 4'(fl); inst_pc = 16'(pc); inst_len = 3'(len);
    disp = 9'(d); cnt_in = 16'(cnt); opnd = 8'(op); mask = 8'(mk);
    n = (fl >> 3) & 1; z = (fl >> 2) & 1; v = (fl >> 1) & 1; c = fl & 1;
    dv = (d & 511) >= 256 ? (d & 511) - 512 : (d & 511);
    cv = cnt & 65535;
    e_cnt = cv;
    if (k == 16 || k == 17) e_cnt = (cv + 65535) % 65536;
    if (k == 18 || k == 19) e_cnt = (cv + 1) % 65536;
    tst = e_cnt;
    case (k)
      0: e_t = 1; 1: e_t = 0;
      2: e_t = (c == 0 && z == 0); 3: e_t = (c == 1 || z == 1);
      4: e_t = (c == 0); 5: e_t = (c == 1);
      6: e_t = (z == 0); 7: e_t = (z == 1);
      8: e_t = (v == 0); 9: e_t = (v == 1);
      10: e_t = (n == 0); 11: e_t = (n == 1);
      12: e_t = (n == v); 13: e_t = (n != v);
      14: e_t = (z == 0 && n == v); 15: e_t = (z == 1 || n != v);
      16, 18, 20: e_t = (tst == 0);
      17, 19, 21: e_t = (tst != 0);
      22: e_t = ((op & mk & 255) == (mk & 255));
      23: e_t = ((op & mk & 255) == 0);
      default: e_t = 0;
    endcase
    base = (k >= 16 && k <= 21) ? pc + 3 : pc + len;
    e_npc = ((base + (e_t ? dv : 0)) % 65536 + 65536) % 65536;
    @(negedge clk);
    checks++;
    if (taken !== e_t) begin
      errors++;
      $display("FAIL %s taken code %0d flags %0h cnt %0h: got %0b exp %0b", tag_of(k), k, fl, cv, taken, e_t);
    end
    checks++;
    if (int'(next_pc) != e_npc) begin
      errors++;
      $display("FAIL %s next_pc code %0d: got %0h exp %0h",
               (k >= 16 && k <= 21) ? "R9" : "R5", k, next_pc, e_npc);
    end
    checks++;
    if (int'(cnt_out) != e_cnt) begin
      errors++;
      $display("FAIL %s cnt_out code %0d: got %0h exp %0h",
               (k >= 16 && k <= 19) ? tag_of(k) : "R11", k, cnt_out, e_cnt);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int pcs[3] = '{16'h1000, 16'hFFFC, 16'h0002};
    int ds[4]  = '{9'h010, 9'h1F0, 9'h0FF, 9'h100};
    int cnts[6] = '{0, 1, 2, 16'h8000, 16'hFFFE, 16'hFFFF};
    // R1 R2 R3 R4 R5 R11: every code under every flag pattern
    for (int k = 0; k < 32; k++)
      for (int fl = 0; fl < 16; fl++)
        for (int p = 0; p < 3; p++)
          run(k, fl, pcs[p], 2 + (fl % 3), ds[(k + fl + p) % 4], 16'h1234, 8'hA5, 8'h0F);
    // R6 R7 R8 R9: counter corners, length input must be ignored
    for (int k = 16; k < 22; k++)
      for (int ci = 0; ci < 6; ci++)
        for (int di = 0; di < 4; di++)
          run(k, ci * 3, pcs[di % 3], 6 - di, ds[di], cnts[ci], 0, 0);
    // R10: bit tests with lengths 4..6, including zero and full masks
    for (int k = 22; k < 24; k++)
      for (int len = 4; len < 7; len++) begin
        run(k, 0, 16'h2000, len, 9'h020, 0, 8'hFF, 8'h81);
        run(k, 0, 16'h2000, len, 9'h1E0, 0, 8'h00, 8'h81);
        run(k, 0, 16'h2000, len, 9'h020, 0, 8'h80, 8'h81);
        run(k, 0, 16'hFFFE, len, 9'h004, 0, 8'h5A, 8'h00);
        run(k, 0, 16'h2000, len, 9'h1FF, 0, 8'h7E, 8'h81);
        run(k, 0, 16'h2000, len, 9'h050, 0, 8'hFF, 8'hFF);
      end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule